// File: doc/BRIEF.md
# Serial Shift-Out Output Expander

This peripheral widens a chip's output pin count by driving a chain of external serial-in/parallel-out shift registers over three wires: a shift clock, a serial data line and a store strobe that copies the shifted bits to the register outputs. Software writes an output image of up to 24 bits into a data register. The block captures the enabled part of that image, clocks it out most significant bit first, and then raises the store strobe for one shift-clock period.

An update can be started by software, or it can run on its own at one of four refresh rates derived from the system clock. The outputs are arranged in two groups: a 16-bit low group and an 8-bit high group. Each group can be left out of the frame. The polarity of the shift clock can be set to suit receivers that sample on either edge. The two lowest outputs can take their values from an external two-bit status input instead of the data register.

Registers are reached over a simple port with valid, write, address and data signals. Reads are combinational on the address and have no side effects.

Top module: `sout_ctrl`

## Requirements
- R1: After reset all five registers read 0, the three pins are low, and no store strobe appears until an update is requested.
- R2: The registers sit at byte offsets 0x00 (control A), 0x04 (control B), 0x08 (data low), 0x0C (data high) and 0x10 (auxiliary). Each is 32 bits, and every bit reads back what was last written, except control A bit 31. Writing 0 to that bit has no effect.
- R3: Writing 1 to control A bit 31 requests one update. The bit reads 1 until the store strobe of that update ends, and then reads 0.
- R4: Control B bit 0 enables the low group (data bits 15:0) and bit 1 enables the high group (bits 23:16). The frame is 24, 16, 8 or 0 bits long, is shifted MSB first, and carries only the enabled bits.
- R5: Control A bit 26 = 0 gives a shift clock that rises in the middle of each bit period. Bit 26 = 1 gives one that falls there. The clock is low when idle in both cases.
- R6: When control A bits 25:24 are 2'b11, outputs 1:0 take their values from `ext_status[1:0]`. Any other value uses data register bits 1:0.
- R7: When control B bits 31:30 are 2'b10, updates repeat every CLK_HZ/f cycles. Rate code bits 26:23 select f: 0 gives 2 Hz, 1 gives 4 Hz, 2 gives 8 Hz, and 3 or any higher code gives 10 Hz.
- R8: With control B bits 31:30 at any value other than 2'b10, no update starts without a software request.
- R9: The frame is captured when the update starts. A data write during a shift shows only in the next update. A request written during an update is served by a second update that follows it.
- R10: Each bit lasts SHIFT_DIV system cycles. The store strobe is high for SHIFT_DIV cycles, after the last bit, while the shift clock and data are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_status | input | 2 | Alternative source for outputs 1:0 |
| store_o | output | 1 | Store strobe to the external registers |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Shift clock |

## Verification
A write is visible in read data on the next sample. A requested update starts one cycle after the write and finishes (24·SHIFT_DIV + SHIFT_DIV) cycles later, at which point the request bit reads 0. Periodic strobes are spaced exactly CLK_HZ/f cycles apart. Instead of sampling at fixed cycles, the bench runs a pin-level receiver at the falling system-clock edge. The receiver captures data on the programmed shift-clock edge, measures the bit spacing and the strobe width, and hands over a finished frame when the strobe falls. The checks wait for that hand-over, or for a count of strobes, under a timeout, and then compare the frame with the expected value.

// File: rtl/sout_pkg.sv
// Shared constants and types for the serial shift-out controller.
// Assumes a byte-addressed register map with five 32-bit registers.
package sout_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CTRL_A  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CTRL_B  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_DATA_LO = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_DATA_HI = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_AUX     = 5'h10;

    localparam int BIT_SWREQ = 31;
    localparam int BIT_EDGE  = 26;
    localparam int BIT_OVR_H = 25;
    localparam int BIT_OVR_L = 24;

    localparam logic [1:0] MODE_PERIODIC = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_STORE
    } ser_state_e;

    typedef struct packed {
        logic       edge_fall;
        logic       grp_lo;
        logic       grp_hi;
        logic       periodic;
        logic [3:0] rate;
    } cfg_t;

endpackage

// File: rtl/sout_regs.sv
// Register file and bus decode for the serial shift-out controller.
// Holds the software request flag and assembles the output image,
// including the external override of outputs 1:0. Assumes NUM_OUT <= 32.
module sout_regs
    import sout_pkg::*;
#(
    parameter int NUM_OUT = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [1:0]         ext_status,
    input  logic               busy,
    input  logic               upd_done,
    output logic               sw_pend,
    output cfg_t               cfg,
    output logic [NUM_OUT-1:0] image
);

    logic [30:0] ctrl_a_q;
    logic [31:0] ctrl_b_q;
    logic [31:0] data_lo_q;
    logic [31:0] data_hi_q;
    logic [31:0] aux_q;
    logic        rearm_q;
    logic        wr_en;
    logic        req_wr;

    assign wr_en  = bus_valid && bus_write;
    assign req_wr = wr_en && (bus_addr == OFF_CTRL_A) && bus_wdata[BIT_SWREQ];

    // Plain storage registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a_q  <= '0;
            ctrl_b_q  <= '0;
            data_lo_q <= '0;
            data_hi_q <= '0;
            aux_q     <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFF_CTRL_A:  ctrl_a_q  <= bus_wdata[30:0];
                OFF_CTRL_B:  ctrl_b_q  <= bus_wdata;
                OFF_DATA_LO: data_lo_q <= bus_wdata;
                OFF_DATA_HI: data_hi_q <= bus_wdata;
                OFF_AUX:     aux_q     <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Software request flag; a request seen mid-update re-arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pend <= 1'b0;
            rearm_q <= 1'b0;
        end else if (req_wr) begin
            sw_pend <= 1'b1;
            rearm_q <= busy && !upd_done;
        end else if (upd_done) begin
            sw_pend <= rearm_q;
            rearm_q <= 1'b0;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (bus_addr)
            OFF_CTRL_A:  bus_rdata = {sw_pend, ctrl_a_q};
            OFF_CTRL_B:  bus_rdata = ctrl_b_q;
            OFF_DATA_LO: bus_rdata = data_lo_q;
            OFF_DATA_HI: bus_rdata = data_hi_q;
            OFF_AUX:     bus_rdata = aux_q;
            default:     bus_rdata = '0;
        endcase
    end

    // Output image with optional status override of bits 1:0.
    always_comb begin
        image = data_lo_q[NUM_OUT-1:0];
        if (ctrl_a_q[BIT_OVR_H] && ctrl_a_q[BIT_OVR_L])
            image[1:0] = ext_status;
    end

    // Decoded configuration fields.
    always_comb begin
        cfg.edge_fall = ctrl_a_q[BIT_EDGE];
        cfg.grp_lo    = ctrl_b_q[0];
        cfg.grp_hi    = ctrl_b_q[1];
        cfg.periodic  = (ctrl_b_q[31:30] == MODE_PERIODIC);
        cfg.rate      = ctrl_b_q[26:23];
    end

endmodule

// File: rtl/sout_refresh.sv
// Refresh prescaler: emits a one-cycle tick every CLK_HZ/f cycles while
// periodic mode is on. Codes above 3 use the fastest rate.
// Assumes CLK_HZ >= 20.
module sout_refresh #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [3:0] rate,
    output logic       tick
);

    localparam int P2  = CLK_HZ / 2;
    localparam int P4  = CLK_HZ / 4;
    localparam int P8  = CLK_HZ / 8;
    localparam int P10 = CLK_HZ / 10;
    localparam int CW  = $clog2(P2 + 1);

    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_q;

    // Period selection from the rate code.
    always_comb begin
        case (rate)
            4'd0:    limit = CW'(P2);
            4'd1:    limit = CW'(P4);
            4'd2:    limit = CW'(P8);
            default: limit = CW'(P10);
        endcase
    end

    assign tick = enable && (cnt_q >= limit - 1'b1);

    // Period counter, held at zero while periodic mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= '0;
        else if (tick)         cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sout_serializer.sv
// Frame serializer: captures the enabled groups at start, shifts them
// MSB first at SHIFT_DIV cycles per bit, then strobes store for one
// bit period. Pins are decoded from registered state only.
// Assumes SHIFT_DIV >= 2 and NUM_OUT > GRP_LO_W.
module sout_serializer
    import sout_pkg::*;
#(
    parameter int NUM_OUT   = 24,
    parameter int GRP_LO_W  = 16,
    parameter int SHIFT_DIV = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM_OUT-1:0] image,
    input  logic               grp_lo,
    input  logic               grp_hi,
    input  logic               edge_fall,
    output logic               busy,
    output logic               done,
    output logic               sclk_o,
    output logic               sdata_o,
    output logic               store_o
);

    localparam int HI_W = NUM_OUT - GRP_LO_W;
    localparam int BW   = $clog2(NUM_OUT + 1);
    localparam int DW   = $clog2(SHIFT_DIV + 1);
    localparam int HALF = SHIFT_DIV / 2;

    ser_state_e         state_q;
    logic [NUM_OUT-1:0] frame_q;
    logic [NUM_OUT-1:0] load_frame;
    logic [BW-1:0]      load_bits;
    logic [BW-1:0]      bits_left_q;
    logic [DW-1:0]      div_q;
    logic               edge_q;
    logic               period_end;

    assign period_end = (div_q == DW'(SHIFT_DIV - 1));

    // Left-align the enabled groups for MSB-first shifting.
    always_comb begin
        case ({grp_hi, grp_lo})
            2'b11: begin
                load_frame = image;
                load_bits  = BW'(NUM_OUT);
            end
            2'b10: begin
                load_frame = {image[NUM_OUT-1:GRP_LO_W], {GRP_LO_W{1'b0}}};
                load_bits  = BW'(HI_W);
            end
            2'b01: begin
                load_frame = {image[GRP_LO_W-1:0], {HI_W{1'b0}}};
                load_bits  = BW'(GRP_LO_W);
            end
            default: begin
                load_frame = '0;
                load_bits  = '0;
            end
        endcase
    end

    // Update sequencer: idle, shift each bit, then hold store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            frame_q     <= '0;
            bits_left_q <= '0;
            div_q       <= '0;
            edge_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        frame_q     <= load_frame;
                        bits_left_q <= load_bits;
                        edge_q      <= edge_fall;
                        div_q       <= '0;
                        state_q     <= (load_bits == '0) ? ST_STORE : ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (period_end) begin
                        div_q       <= '0;
                        frame_q     <= frame_q << 1;
                        bits_left_q <= bits_left_q - 1'b1;
                        if (bits_left_q == BW'(1)) state_q <= ST_STORE;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                ST_STORE: begin
                    if (period_end) begin
                        div_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_STORE) && period_end;
    assign store_o = (state_q == ST_STORE);
    assign sdata_o = (state_q == ST_SHIFT) && frame_q[NUM_OUT-1];
    assign sclk_o  = (state_q == ST_SHIFT) && ((div_q >= DW'(HALF)) ^ edge_q);

endmodule

// File: rtl/sout_ctrl.sv
// Top of the serial shift-out controller: register file, refresh
// prescaler and frame serializer. An update starts whenever the
// serializer is idle and either a software request or a refresh tick
// is present.
module sout_ctrl
    import sout_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SHIFT_DIV = 8,
    parameter int NUM_OUT   = 24,
    parameter int GRP_LO_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  ext_status,
    output logic        store_o,
    output logic        sdata_o,
    output logic        sclk_o
);

    cfg_t               cfg;
    logic [NUM_OUT-1:0] image;
    logic               sw_pend;
    logic               busy;
    logic               done;
    logic               tick;
    logic               start;
    logic               periodic_en;

    assign periodic_en = cfg.periodic;
    assign start       = !busy && (sw_pend || tick);

    sout_regs #(.NUM_OUT(NUM_OUT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_status (ext_status),
        .busy       (busy),
        .upd_done   (done),
        .sw_pend    (sw_pend),
        .cfg        (cfg),
        .image      (image)
    );

    sout_refresh #(.CLK_HZ(CLK_HZ)) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (periodic_en),
        .rate   (cfg.rate),
        .tick   (tick)
    );

    sout_serializer #(
        .NUM_OUT   (NUM_OUT),
        .GRP_LO_W  (GRP_LO_W),
        .SHIFT_DIV (SHIFT_DIV)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .image     (image),
        .grp_lo    (cfg.grp_lo),
        .grp_hi    (cfg.grp_hi),
        .edge_fall (cfg.edge_fall),
        .busy      (busy),
        .done      (done),
        .sclk_o    (sclk_o),
        .sdata_o   (sdata_o),
        .store_o   (store_o)
    );

endmodule

// File: rtl/sout_checker.sv
// Protocol checker for sout_ctrl, attached by bind. It relates the pins
// to the sequencer activity and the refresh tick to the update mode.
module sout_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic tick,
    input logic sw_pend,
    input logic periodic_en,
    input logic sclk_o,
    input logic sdata_o,
    input logic store_o
);

    // R1: pins stay low while no update runs.
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk_o && !sdata_o && !store_o));

    // R10: during the store strobe the shift clock and data are low.
    a_r10_store_clean: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> (!sclk_o && !sdata_o));

    // R8: no refresh tick outside periodic mode.
    a_r8_no_tick_sw_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !periodic_en |-> !tick);

    // R3: an update only begins after a request or a tick.
    a_r3_start_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sw_pend || tick));

endmodule

bind sout_ctrl sout_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .tick        (tick),
    .sw_pend     (sw_pend),
    .periodic_en (periodic_en),
    .sclk_o      (sclk_o),
    .sdata_o     (sdata_o),
    .store_o     (store_o)
);

// File: tb/sout_ctrl_tb.sv
module sout_ctrl_tb;

    localparam int CLK_HZ    = 4000;
    localparam int SHIFT_DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ext_status = '0;
    logic        store_o, sdata_o, sclk_o;

    int checks = 0;
    int errors = 0;

    sout_ctrl #(.CLK_HZ(CLK_HZ), .SHIFT_DIV(SHIFT_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_status(ext_status), .store_o(store_o), .sdata_o(sdata_o), .sclk_o(sclk_o)
    );

    always #10 clk = ~clk;

    // Pin-level receiver model.
    logic        mon_fall = 1'b0;
    logic        prev_sclk = 1'b0, prev_store = 1'b0;
    logic [31:0] cap_val = '0, last_frame = '0;
    int cyc = 0, cap_n = 0, last_cap = 0, slen = 0, last_n = 0, last_slen = 0;
    int frames = 0, rises = 0, last_rise = 0, rise_int = 0;
    logic gap_bad = 1'b0, last_gap_bad = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if ((mon_fall && prev_sclk && !sclk_o) || (!mon_fall && !prev_sclk && sclk_o)) begin
            if (cap_n > 0 && (cyc - last_cap) != SHIFT_DIV) gap_bad = 1'b1;
            cap_val = {cap_val[30:0], sdata_o};
            cap_n++;
            last_cap = cyc;
        end
        if (store_o) slen++;
        if (store_o && !prev_store) begin
            rises++;
            rise_int = cyc - last_rise;
            last_rise = cyc;
        end
        if (!store_o && prev_store) begin
            frames++;
            last_frame = cap_val; last_n = cap_n; last_slen = slen; last_gap_bad = gap_bad;
            cap_val = '0; cap_n = 0; slen = 0; gap_bad = 1'b0;
        end
        prev_sclk = sclk_o;
        prev_store = store_o;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_frames(input int target);
        int t = 0;
        while (frames < target && t < 6000) begin @(negedge clk); t++; end
    endtask

    task automatic wait_rises(input int target);
        int t = 0;
        while (rises < target && t < 7000) begin @(negedge clk); t++; end
    endtask

    function automatic logic [31:0] exp_frame(input logic [31:0] d, input logic [1:0] e,
                                              input logic [1:0] ov, input logic lo, input logic hi);
        logic [23:0] img;
        img = d[23:0];
        if (ov == 2'b11) img[1:0] = e;
        case ({hi, lo})
            2'b11:   return {8'b0, img};
            2'b10:   return {24'b0, img[23:16]};
            2'b01:   return {16'b0, img[15:0]};
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_a_word(input logic req, input logic edge_f, input logic [1:0] ov);
        return {req, 4'b0, edge_f, ov, 24'b0};
    endfunction

    function automatic logic [31:0] ctrl_b_word(input logic [1:0] mode, input logic [3:0] rate,
                                                input logic hi, input logic lo);
        return {mode, 3'b0, rate, 20'b0, 1'b0, hi, lo};
    endfunction

    // One software update with full frame checks (R3, R4, R5, R6, R10).
    task automatic sw_update(input logic [31:0] d, input logic [1:0] e, input logic [1:0] ov,
                             input logic edge_f, input logic lo, input logic hi);
        int base;
        logic [31:0] rd;
        ext_status = e;
        bus_wr(5'h04, ctrl_b_word(2'b00, 4'd0, hi, lo));
        bus_wr(5'h08, d);
        mon_fall = edge_f;
        base = frames;
        bus_wr(5'h00, ctrl_a_word(1'b1, edge_f, ov));
        wait_frames(base + 1);
        chk(frames == base + 1, "R3 one update per request", frames, base + 1);
        chk(last_frame == exp_frame(d, e, ov, lo, hi), "R4/R5/R6 frame content",
            last_frame, exp_frame(d, e, ov, lo, hi));
        chk(last_n == 16 * lo + 8 * hi, "R4 frame length", last_n, 16 * lo + 8 * hi);
        chk(last_slen == SHIFT_DIV && !last_gap_bad, "R10 bit period and strobe width",
            last_slen, SHIFT_DIV);
        bus_rd(5'h00, rd);
        chk(rd[31] == 1'b0, "R3 request bit clears", rd[31], 0);
    endtask

    initial begin
        logic [31:0] rd;
        int base;
        void'($urandom(32'h5EED_0C7A));

        repeat (4) @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            bus_rd(5'(i * 4), rd);
            chk(rd == 32'h0, "R1 register reset value", rd, 0);
        end
        rst_n = 1'b1;
        repeat (500) @(negedge clk);
        chk(!store_o && !sdata_o && !sclk_o, "R1 pins idle low", {store_o, sdata_o, sclk_o}, 0);
        chk(frames == 0, "R1 no update without request", frames, 0);

        // R2 register read-back
        bus_wr(5'h0C, 32'hDEAD_BEEF);
        bus_rd(5'h0C, rd); chk(rd == 32'hDEAD_BEEF, "R2 data high read-back", rd, 32'hDEAD_BEEF);
        bus_wr(5'h10, 32'h1234_5678);
        bus_rd(5'h10, rd); chk(rd == 32'h1234_5678, "R2 auxiliary read-back", rd, 32'h1234_5678);
        bus_wr(5'h04, 32'h0780_0007);
        bus_rd(5'h04, rd); chk(rd == 32'h0780_0007, "R2 control B read-back", rd, 32'h0780_0007);
        bus_wr(5'h00, 32'h0755_AA11);
        bus_rd(5'h00, rd); chk(rd == 32'h0755_AA11, "R2 control A without request", rd, 32'h0755_AA11);
        repeat (300) @(negedge clk);
        chk(frames == 0, "R2 zero in request bit starts nothing", frames, 0);
        bus_wr(5'h00, 32'h0);

        // Directed corner cases
        sw_update(32'h00A5_C3F0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1);   // R4 both groups, R5 rising
        sw_update(32'h00A5_C3F0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1);   // R5 falling edge
        sw_update(32'h0081_8001, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1);   // R4 high group only
        sw_update(32'h0081_8001, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0);   // R4 low group only
        sw_update(32'h00FF_FFFF, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);   // R4 no group
        sw_update(32'h0000_0001, 2'b10, 2'b11, 1'b0, 1'b1, 1'b1);   // R6 override on
        sw_update(32'h0000_0001, 2'b10, 2'b01, 1'b0, 1'b1, 1'b1);   // R6 override off

        // Random patterns
        for (int i = 0; i < 16; i++) begin
            logic [31:0] d;
            logic [3:0] r;
            d = $urandom;
            r = 4'($urandom);
            sw_update(d, r[1:0], 2'($urandom), r[2], r[3] | (i[0]), r[3] | ~i[0]);
        end

        // R9 snapshot and request during an update
        bus_wr(5'h04, ctrl_b_word(2'b00, 4'd0, 1'b1, 1'b1));
        bus_wr(5'h08, 32'h0012_3456);
        mon_fall = 1'b0;
        base = frames;
        bus_wr(5'h00, ctrl_a_word(1'b1, 1'b0, 2'b00));
        repeat (40) @(negedge clk);
        bus_wr(5'h08, 32'h00AB_CDEF);
        bus_wr(5'h00, ctrl_a_word(1'b1, 1'b0, 2'b00));
        wait_frames(base + 1);
        chk(last_frame == 32'h0012_3456, "R9 frame uses start-time data", last_frame, 32'h0012_3456);
        wait_frames(base + 2);
        chk(last_frame == 32'h00AB_CDEF, "R9 mid-update request gives second update",
            last_frame, 32'h00AB_CDEF);
        repeat (400) @(negedge clk);
        chk(frames == base + 2, "R9 no extra update", frames, base + 2);

        // R7 periodic refresh rates
        bus_wr(5'h04, ctrl_b_word(2'b10, 4'd3, 1'b1, 1'b1));
        base = rises;
        wait_rises(base + 3);
        chk(rise_int == CLK_HZ / 10, "R7 10 Hz interval", rise_int, CLK_HZ / 10);
        bus_wr(5'h04, ctrl_b_word(2'b10, 4'd0, 1'b1, 1'b1));
        base = rises;
        wait_rises(base + 3);
        chk(rise_int == CLK_HZ / 2, "R7 2 Hz interval", rise_int, CLK_HZ / 2);
        bus_wr(5'h04, ctrl_b_word(2'b10, 4'd1, 1'b1, 1'b1));
        base = rises;
        wait_rises(base + 3);
        chk(rise_int == CLK_HZ / 4, "R7 4 Hz interval", rise_int, CLK_HZ / 4);

        // R8 software-only mode stops refresh
        bus_wr(5'h04, ctrl_b_word(2'b01, 4'd3, 1'b1, 1'b1));
        repeat (300) @(negedge clk);
        base = frames;
        repeat (2500) @(negedge clk);
        chk(frames == base, "R8 no refresh outside periodic mode", frames, base);

        summary();
        $finish;
    end

endmodule